// File: doc/BRIEF.md
# Masked Bit-Manipulation Unit

This execution unit produces one word from a source operand `x` by pairing a simple transform of `x` (the word itself or its complement) with an arithmetic transform of `x` (increment, decrement, or one of their complemented forms). The two are joined through a bitwise OR, AND or XOR. A five-bit mode field picks one of 24 operations. This set covers the usual lowest-set-bit tricks: isolate, clear, fill and mask-up-to.

A per-lane predicate restricts which bits take the computed value. For lanes outside the predicate, a keep flag chooses between passing the source bit through and forcing zero. An indicator marks the case where no mask operand exists, and the predicate is then treated as all ones. Mode codes with operator bits `11` are reserved. They raise an illegal flag and yield a zero result. The result is registered once, so it appears one cycle after a valid input.

Top module: `bmu_top`

## Requirements
- R1: While `rst_ni` is low, and before the first valid input after reset, `valid_o`, `illegal_o` and `result_o` are all zero.
- R2: `valid_o` is high in exactly the cycle after a cycle in which `valid_i` was high at the clock edge, and low otherwise.
- R3: Mode bit 4 selects the first operand: 0 uses `x` and 1 uses `~x`.
- R4: Mode bits [1:0] select the joining operator: `00` is OR, `01` is AND, `10` is XOR.
- R5: Mode bits [3:2] select the arithmetic operand: `00` is x+1, `01` is x-1, `10` is ~(x+1), `11` is (~x)+1. All arithmetic wraps modulo 2^W.
- R6: A result bit whose mask bit is 1 carries the joined value of that lane.
- R7: A result bit whose mask bit is 0 equals the source bit when `keep_i` is 1, and equals 0 when `keep_i` is 0.
- R8: When `mask_zero_i` is 1, `mask_i` is ignored and every lane is treated as selected.
- R9: Mode bits [1:0] equal to `11` set `illegal_o` to 1 and force `result_o` to zero. Every other mode sets `illegal_o` to 0.
- R10: `result_o` and `illegal_o` hold their last values through cycles in which `valid_i` is low.
- R11: Mode `00101` (x & (x-1)) clears the lowest set bit. Mode `00110` (x ^ (x-1)) gives ones up to and including the lowest set bit. With x=0 it gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| src_i | input | W | Source word x |
| mask_i | input | W | Lane predicate |
| mask_zero_i | input | 1 | No mask operand; treat predicate as all ones |
| mode_i | input | 5 | Operation select {inv, arith[1:0], op[1:0]} |
| keep_i | input | 1 | Unselected lanes pass source (1) or zero (0) |
| valid_o | output | 1 | Result valid |
| result_o | output | W | Registered result |
| illegal_o | output | 1 | Reserved mode was issued |

## Verification
The only state is the output register, so a fault there shows up at the ports on the very next valid cycle. A wrong enable or a lost hold shows as a result that changes while `valid_i` is low. A bad decode or a swapped operand order in the datapath shows as a miscompare against the bench model in the cycle after the offending input. Carry faults are reached with zero, all-ones and lowest-set-bit operands. Predicate faults are reached with random masks and with both keep settings.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    OP_OR  = 2'b00,
    OP_AND = 2'b01,
    OP_XOR = 2'b10,
    OP_RSV = 2'b11
  } bmu_op_e;

  typedef enum logic [1:0] {
    AR_INC  = 2'b00,
    AR_DEC  = 2'b01,
    AR_NINC = 2'b10,
    AR_NEG  = 2'b11
  } bmu_arith_e;

  // bit layout matches mode_i: [4] inv, [3:2] arith, [1:0] op
  typedef struct packed {
    logic       inv_a;
    bmu_arith_e arith;
    bmu_op_e    op;
  } bmu_mode_t;
endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [4:0] mode_i,
  output bmu_mode_t  dec_o,
  output logic       illegal_o
);
  always_comb begin
    dec_o     = bmu_mode_t'(mode_i);
    illegal_o = (dec_o.op == OP_RSV);
  end
endmodule

// File: rtl/bmu_arith.sv
module bmu_arith
  import bmu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] src_i,
  input  bmu_arith_e   sel_i,
  output logic [W-1:0] arith_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] inc, dec, neg;

  always_comb begin
    inc = src_i + ONE;
    dec = src_i - ONE;
    neg = (~src_i) + ONE;
    unique case (sel_i)
      AR_INC:  arith_o = inc;
      AR_DEC:  arith_o = dec;
      AR_NINC: arith_o = ~inc;
      default: arith_o = neg;
    endcase
  end
endmodule

// File: rtl/bmu_combine.sv
module bmu_combine
  import bmu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] arith_i,
  input  logic         inv_a_i,
  input  bmu_op_e      op_i,
  input  logic [W-1:0] mask_i,
  input  logic         keep_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] opa, joined;

  always_comb begin
    opa = inv_a_i ? ~src_i : src_i;
    unique case (op_i)
      OP_OR:   joined = opa | arith_i;
      OP_AND:  joined = opa & arith_i;
      OP_XOR:  joined = opa ^ arith_i;
      default: joined = '0;
    endcase
  end

  // per-lane select between joined value and pass/zero
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign res_o[i] = mask_i[i] ? joined[i] : (keep_i & src_i[i]);
  end
endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  input  logic         mask_zero_i,
  input  logic [4:0]   mode_i,
  input  logic         keep_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         illegal_o
);
  bmu_mode_t    dec;
  logic         ill;
  logic [W-1:0] arith, mask_eff, comb_res, res_d;

  bmu_decode u_dec (
    .mode_i    (mode_i),
    .dec_o     (dec),
    .illegal_o (ill)
  );

  bmu_arith #(.W(W)) u_arith (
    .src_i   (src_i),
    .sel_i   (dec.arith),
    .arith_o (arith)
  );

  assign mask_eff = mask_zero_i ? '1 : mask_i;

  bmu_combine #(.W(W)) u_comb (
    .src_i   (src_i),
    .arith_i (arith),
    .inv_a_i (dec.inv_a),
    .op_i    (dec.op),
    .mask_i  (mask_eff),
    .keep_i  (keep_i),
    .res_o   (comb_res)
  );

  assign res_d = ill ? '0 : comb_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= res_d;
        illegal_o <= ill;
      end
    end
  end
endmodule

// File: rtl/bmu_chk.sv
module bmu_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] src_i,
  input logic [W-1:0] mask_i,
  input logic         mask_zero_i,
  input logic [4:0]   mode_i,
  input logic         keep_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         illegal_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R9
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (illegal_o == ($past(mode_i[1:0]) == 2'b11)));
  // R9
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (result_o == '0));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o)));
  // R7
  keep_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && keep_i && !mask_zero_i && mode_i[1:0] != 2'b11)
      |=> (((result_o ^ $past(src_i)) & ~$past(mask_i)) == '0));
  // R7
  zero_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !keep_i && !mask_zero_i) |=> ((result_o & ~$past(mask_i)) == '0));
endmodule

bind bmu_top bmu_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .src_i       (src_i),
  .mask_i      (mask_i),
  .mask_zero_i (mask_zero_i),
  .mode_i      (mode_i),
  .keep_i      (keep_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .illegal_o   (illegal_o)
);

// File: tb/tb_bmu_top.sv
`timescale 1ns/1ps
module tb_bmu_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [W-1:0] src = '0, mask = '0;
  logic         mz = 1'b0, keep = 1'b0;
  logic [4:0]   mode = '0;
  logic         valid_o, illegal_o;
  logic [W-1:0] result_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  bmu_top #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src_i(src), .mask_i(mask),
    .mask_zero_i(mz), .mode_i(mode), .keep_i(keep),
    .valid_o(valid_o), .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic logic [W-1:0] arith_m(logic [W-1:0] x, logic [1:0] s);
    case (s)
      2'd0: return x + 1;
      2'd1: return x - 1;
      2'd2: return ~(x + 1);
      default: return (~x) + 1;
    endcase
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] m,
                                         logic z, logic [4:0] md, logic k);
    logic [W-1:0] a, c, j, me;
    a  = md[4] ? ~x : x;
    c  = arith_m(x, md[3:2]);
    case (md[1:0])
      2'd0: j = a | c;
      2'd1: j = a & c;
      2'd2: j = a ^ c;
      default: return '0;
    endcase
    me = z ? '1 : m;
    return (j & me) | (k ? (x & ~me) : '0);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [W-1:0] x, logic [W-1:0] m,
                       logic z, logic [4:0] md, logic k);
    @(negedge clk);
    valid = 1'b1; src = x; mask = m; mz = z; mode = md; keep = k;
    @(negedge clk);
    valid = 1'b0;
    check("R2", W'(valid_o), W'(1));
    check(req, result_o, model(x, m, z, md, k));
    check("R9", W'(illegal_o), W'(md[1:0] == 2'b11));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'h5eed_b17));
    #23;
    check("R1", {result_o[W-1:2], valid_o, illegal_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {result_o[W-1:2], valid_o, illegal_o}, '0);

    // R11 directed
    apply("R11", 64'h58, '0, 1'b1, 5'b00101, 1'b0);
    check("R11", result_o, 64'h50);
    apply("R11", 64'h58, '0, 1'b1, 5'b00110, 1'b0);
    check("R11", result_o, 64'h0F);
    apply("R11", '0, '0, 1'b1, 5'b00110, 1'b0);
    check("R11", result_o, '1);
    apply("R11", '0, '0, 1'b1, 5'b00101, 1'b0);
    apply("R11", '1, '0, 1'b1, 5'b00101, 1'b0);
    check("R11", result_o, {{(W-1){1'b1}}, 1'b0});
    apply("R11", '1, '0, 1'b1, 5'b00110, 1'b0);
    check("R11", result_o, 64'h1);
    // R5 wrap corners
    apply("R5", '1, '0, 1'b1, 5'b00000, 1'b0);
    apply("R5", '0, '0, 1'b1, 5'b01111, 1'b0);
    apply("R5", '0, '0, 1'b1, 5'b01000, 1'b0);
    // R3 inverted first operand
    apply("R3", 64'h58, '0, 1'b1, 5'b10001, 1'b0);
    // R8: mask ignored when zero indicator set
    apply("R8", 64'h1234_5678_9abc_def0, '0, 1'b1, 5'b00010, 1'b0);
    // R6/R7 lane selection with keep and zero
    apply("R7", 64'hffff_0000_aaaa_5555, 64'h00ff_00ff_00ff_00ff, 1'b0, 5'b00110, 1'b1);
    apply("R7", 64'hffff_0000_aaaa_5555, 64'h00ff_00ff_00ff_00ff, 1'b0, 5'b00110, 1'b0);
    apply("R6", 64'h0f0f_0f0f_0f0f_0f0f, 64'hf0f0_f0f0_f0f0_f0f0, 1'b0, 5'b10000, 1'b1);
    // R9 reserved
    apply("R9", 64'hdead_beef, '1, 1'b0, 5'b01011, 1'b1);
    check("R9", result_o, '0);

    // R10 hold and R2 idle
    apply("R10", 64'h80, '0, 1'b1, 5'b00101, 1'b0);
    held = result_o;
    src = '1; mode = 5'b00000; keep = 1'b1;
    @(negedge clk);
    check("R2", W'(valid_o), W'(0));
    check("R10", result_o, held);
    @(negedge clk);
    check("R10", result_o, held);

    // random
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, m;
      logic [4:0] md;
      x  = {$urandom, $urandom};
      m  = {$urandom, $urandom};
      md = 5'($urandom);
      if (i % 7 == 0) x = x & (x - 1) & ~(x >> 3);
      apply(md[1:0] == 2'b11 ? "R9" : "R4", x, m, 1'($urandom), md, 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule